// File: doc/BRIEF.md
# Pulse-Width-Coded Register-Mode Clock Encoder

This block drives the master clock line of a point-to-multipoint sensor link while the link is in register-access mode. Commands travel from master to slaves without a data wire. Each clock period carries one command bit, and the bit's value sets how long the line stays high within that period. A short high phase means 0 and a long high phase means 1. After the command bits, the block can emit a set number of plain clock periods with a half-period high phase. The slaves use these periods to shift their reply back. Sampling that reply is handled elsewhere.

A frame begins when `start_i` is seen while the slaves report ready and the encoder is idle. On that edge the block captures the command word, the command length, the readout count and the quarter-period length. Later changes on those inputs do not affect the running frame. Every period is exactly four quarters long, so the 25 %, 50 % and 75 % points fall on whole system-clock cycles. When the last period ends, a single-cycle done pulse is given and the block returns to idle.

The control state machine has four states. **IDLE** holds the line high and waits. **SEND** emits command periods. **READ** emits readout periods. **WRAP** is the one-cycle done state. Its transitions are:
- *accept*: IDLE to SEND when there are command bits.
- *accept-read*: IDLE to READ when there are no command bits but the readout count is non-zero.
- *accept-empty*: IDLE to WRAP when both counts are zero.
- *next-bit*: SEND to SEND on a period end that is not the last command bit.
- *to-read*: SEND to READ on the last command bit when readout periods follow.
- *send-end*: SEND to WRAP on the last command bit when no readout periods follow.
- *next-read*: READ to READ on a period end that is not the last readout period.
- *read-end*: READ to WRAP on the last readout period.
- *release*: WRAP to IDLE, always.

Top module: `regclk_pwm_enc`

## Requirements
- R1: After reset and whenever no frame is running, `ma_o` is 1, `busy_o` is 0 and `done_o` is 0.
- R2: A `start_i` seen while `slaves_rdy_i` is 0 is ignored. No period is produced and `busy_o` stays 0.
- R3: A frame is accepted on a clock edge where the block is idle and both `start_i` and `slaves_rdy_i` are 1. From the next cycle on, `busy_o` is 1. Each period lasts 4·(`qtr_len_i`+1) cycles, with `qtr_len_i` captured at acceptance, and each period opens with its high phase.
- R4: A command bit of value 0 gives a high phase of one quarter followed by three quarters low. A command bit of value 1 gives three quarters high followed by one quarter low.
- R5: The command bits sent are `cmd_word_i[cmd_len_i-1:0]`. They go out most significant first and end with bit 0.
- R6: After the command bits come exactly `rd_len_i` readout periods. Each is two quarters high and then two quarters low.
- R7: In the cycle after the last period, `done_o` is 1 for exactly one cycle, with `busy_o` 0 and `ma_o` 1. The block is idle in the cycle after that.
- R8: If `cmd_len_i` is 0 but `rd_len_i` is not, the frame consists of readout periods only.
- R9: If `cmd_len_i` and `rd_len_i` are both 0, acceptance produces the done pulse in the next cycle and no period.
- R10: A `cmd_len_i` larger than CMD_W (16) is treated as CMD_W.
- R11: While a frame runs, `start_i`, `slaves_rdy_i`, `cmd_word_i`, `cmd_len_i`, `rd_len_i` and `qtr_len_i` have no effect on the frame.
- R12: A `start_i` held through the done cycle is not taken in that cycle. It is accepted in the following idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request |
| slaves_rdy_i | input | 1 | Slaves ready for register-mode traffic |
| cmd_len_i | input | 5 | Number of command bits (0..CMD_W, larger values clamp) |
| cmd_word_i | input | 16 | Command bits, right-aligned |
| rd_len_i | input | 8 | Number of readout periods after the command |
| qtr_len_i | input | 8 | Quarter-period length minus one, in system clocks |
| ma_o | output | 1 | Encoded master clock line |
| busy_o | output | 1 | High while periods are being emitted |
| done_o | output | 1 | One-cycle pulse after the last period |

## Verification
The bench targets several corner cases. A quarter length of one cycle catches an off-by-one in the quarter counter, which would stretch or shrink every phase. A command word with asymmetric bits catches reversed bit order, since that would swap 25 % and 75 % phases at the mirrored positions. Frames with only readout periods, with no periods at all, and with an over-long command length catch a machine that stalls, emits a stray period, or wraps the bit count. Toggling every input in the middle of a frame, and holding start through the done cycle, catch a design that fails to capture its settings at acceptance or that re-triggers one cycle too early.

// File: rtl/regclk_pkg.sv
package regclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_READ = 2'd2,
        ST_WRAP = 2'd3
    } enc_state_t;

    // high-phase length in quarters for each period kind
    localparam logic [1:0] HQ_ZERO = 2'd1;
    localparam logic [1:0] HQ_ONE  = 2'd3;
    localparam logic [1:0] HQ_READ = 2'd2;

endpackage

// File: rtl/regclk_qtimer.sv
module regclk_qtimer #(
    parameter int QTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [QTR_W-1:0] qlen,
    output logic [1:0]       qidx,
    output logic             period_end
);

    logic [QTR_W-1:0] cnt_q;
    logic [1:0]       idx_q;
    logic             qtr_end;

    assign qtr_end = (cnt_q == qlen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (qtr_end) begin
            cnt_q <= '0;
            idx_q <= idx_q + 2'd1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qidx       = idx_q;
    assign period_end = run && qtr_end && (idx_q == 2'd3);

endmodule

// File: rtl/regclk_cmd_shift.sv
module regclk_cmd_shift #(
    parameter int CMD_W = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [CMD_W-1:0] word,
    input  logic [LEN_W-1:0] len,
    output logic             cur_bit,
    output logic             last_bit
);

    logic [CMD_W-1:0] sh_q;
    logic [LEN_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            // left-align so the first bit to send sits at the top
            sh_q   <= word << (LEN_W'(CMD_W) - len);
            left_q <= len;
        end else if (shift) begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign cur_bit  = sh_q[CMD_W-1];
    assign last_bit = (left_q == LEN_W'(1));

endmodule

// File: rtl/regclk_fsm.sv
module regclk_fsm
    import regclk_pkg::*;
#(
    parameter int RD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            rdy,
    input  logic            cmd_nz,
    input  logic [RD_W-1:0] rd_len,
    input  logic            period_end,
    input  logic            cmd_bit,
    input  logic            cmd_last,
    input  logic [1:0]      qidx,
    output logic            accept,
    output logic            run,
    output logic            cmd_shift,
    output logic            ma,
    output logic            busy,
    output logic            done
);

    enc_state_t      state_q, state_d;
    logic [RD_W-1:0] rd_left_q;

    assign accept    = (state_q == ST_IDLE) && start && rdy;
    assign run       = (state_q == ST_SEND) || (state_q == ST_READ);
    assign cmd_shift = (state_q == ST_SEND) && period_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                rd_left_q <= '0;
        else if (accept)                           rd_left_q <= rd_len;
        else if (state_q == ST_READ && period_end) rd_left_q <= rd_left_q - 1'b1;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cmd_nz)             state_d = ST_SEND;  // accept
                    else if (rd_len != '0)  state_d = ST_READ;  // accept-read
                    else                    state_d = ST_WRAP;  // accept-empty
                end
            end
            ST_SEND: begin
                if (period_end && cmd_last) begin
                    if (rd_left_q != '0)    state_d = ST_READ;  // to-read
                    else                    state_d = ST_WRAP;  // send-end
                end
            end
            ST_READ: begin
                if (period_end && rd_left_q == RD_W'(1))
                    state_d = ST_WRAP;                          // read-end
            end
            ST_WRAP: state_d = ST_IDLE;                         // release
        endcase
    end

    // outputs
    always_comb begin
        ma   = 1'b1;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEND: begin
                busy = 1'b1;
                ma   = qidx < (cmd_bit ? HQ_ONE : HQ_ZERO);
            end
            ST_READ: begin
                busy = 1'b1;
                ma   = qidx < HQ_READ;
            end
            ST_WRAP: done = 1'b1;
        endcase
    end

endmodule

// File: rtl/regclk_pwm_enc.sv
module regclk_pwm_enc #(
    parameter int CMD_W = 16,
    parameter int RD_W  = 8,
    parameter int QTR_W = 8,
    localparam int LEN_W = $clog2(CMD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             slaves_rdy_i,
    input  logic [LEN_W-1:0] cmd_len_i,
    input  logic [CMD_W-1:0] cmd_word_i,
    input  logic [RD_W-1:0]  rd_len_i,
    input  logic [QTR_W-1:0] qtr_len_i,
    output logic             ma_o,
    output logic             busy_o,
    output logic             done_o
);

    logic [LEN_W-1:0] len_eff;
    logic [QTR_W-1:0] qlen_q;
    logic             accept, run, cmd_shift, period_end;
    logic             cmd_bit, cmd_last;
    logic [1:0]       qidx;

    assign len_eff = (cmd_len_i > LEN_W'(CMD_W)) ? LEN_W'(CMD_W) : cmd_len_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      qlen_q <= '0;
        else if (accept) qlen_q <= qtr_len_i;
    end

    regclk_qtimer #(.QTR_W(QTR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .qlen       (qlen_q),
        .qidx       (qidx),
        .period_end (period_end)
    );

    regclk_cmd_shift #(.CMD_W(CMD_W), .LEN_W(LEN_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    (cmd_shift),
        .word     (cmd_word_i),
        .len      (len_eff),
        .cur_bit  (cmd_bit),
        .last_bit (cmd_last)
    );

    regclk_fsm #(.RD_W(RD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .rdy        (slaves_rdy_i),
        .cmd_nz     (len_eff != '0),
        .rd_len     (rd_len_i),
        .period_end (period_end),
        .cmd_bit    (cmd_bit),
        .cmd_last   (cmd_last),
        .qidx       (qidx),
        .accept     (accept),
        .run        (run),
        .cmd_shift  (cmd_shift),
        .ma         (ma_o),
        .busy       (busy_o),
        .done       (done_o)
    );

endmodule

// File: rtl/regclk_pwm_enc_chk.sv
module regclk_pwm_enc_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic slaves_rdy_i,
    input logic ma_o,
    input logic busy_o,
    input logic done_o
);

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ma_o);

    a_r2_unready_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !slaves_rdy_i && !busy_o && !done_o) |=> (!busy_o && !done_o));

    a_r3_period_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ma_o);

    a_r3_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i && slaves_rdy_i));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

bind regclk_pwm_enc regclk_pwm_enc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .slaves_rdy_i (slaves_rdy_i),
    .ma_o         (ma_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/sim_regclk_pwm_enc.sv
module sim_regclk_pwm_enc;

    localparam int CMD_W = 16;
    localparam int LEN_W = 5;
    localparam int RD_W  = 8;
    localparam int QTR_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rdy = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [CMD_W-1:0] cmd_word = '0;
    logic [RD_W-1:0]  rd_len = '0;
    logic [QTR_W-1:0] qtr = '0;
    logic             ma, busy, done;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // reference model state
    bit m_ma = 1'b1;
    bit m_busy = 1'b0;
    bit m_done = 1'b0;
    bit exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    regclk_pwm_enc #(.CMD_W(CMD_W), .RD_W(RD_W), .QTR_W(QTR_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .slaves_rdy_i (rdy),
        .cmd_len_i    (cmd_len),
        .cmd_word_i   (cmd_word),
        .rd_len_i     (rd_len),
        .qtr_len_i    (qtr),
        .ma_o         (ma),
        .busy_o       (busy),
        .done_o       (done)
    );

    task automatic push_period(int hq, int q);
        for (int k = 0; k < 4 * q; k++) exp_q.push_back(k < hq * q);
    endtask

    task automatic build_frame();
        int n = (int'(cmd_len) > CMD_W) ? CMD_W : int'(cmd_len);
        int q = int'(qtr) + 1;
        exp_q.delete();
        for (int i = n - 1; i >= 0; i--) push_period(cmd_word[i] ? 3 : 1, q);
        for (int r = 0; r < int'(rd_len); r++) push_period(2, q);
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ma = 1'b1; m_busy = 1'b0; m_done = 1'b0;
            exp_q.delete();
        end else if (m_busy) begin
            if (exp_q.size() == 0) begin
                m_busy = 1'b0; m_done = 1'b1; m_ma = 1'b1;
            end else begin
                m_ma = exp_q.pop_front();
            end
        end else if (m_done) begin
            m_done = 1'b0;
        end else if (start && rdy) begin
            build_frame();
            if (exp_q.size() == 0) m_done = 1'b1;
            else begin
                m_busy = 1'b1;
                m_ma = exp_q.pop_front();
            end
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if ({ma, busy, done} !== {m_ma, m_busy, m_done}) begin
                errors++;
                $display("FAIL %s t=%0t ma/busy/done actual %b%b%b expected %b%b%b",
                         cur_req, $time, ma, busy, done, m_ma, m_busy, m_done);
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy || m_done) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic [LEN_W-1:0] l, input logic [CMD_W-1:0] w,
                         input logic [RD_W-1:0] r, input logic [QTR_W-1:0] qq);
        @(negedge clk);
        cmd_len = l; cmd_word = w; rd_len = r; qtr = qq; rdy = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    initial begin
        // R1: reset state, checked while reset is held
        repeat (2) @(negedge clk);
        checks++;
        if ({ma, busy, done} !== 3'b100) begin
            errors++;
            $display("FAIL R1 reset actual %b%b%b expected 100", ma, busy, done);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: request while slaves not ready
        cur_req = "R2";
        rdy = 1'b0; start = 1'b1; cmd_len = 5'd4; cmd_word = 16'hF;
        repeat (6) @(negedge clk);
        start = 1'b0;
        checks++;
        if (busy !== 1'b0 || ma !== 1'b1) begin
            errors++;
            $display("FAIL R2 busy/ma actual %b%b expected 01", busy, ma);
        end

        // R3 R4 R5 R6: mixed bits, readout, one-cycle quarters
        cur_req = "R3/R4/R5/R6";
        frame(5'd4, 16'h000A, 8'd2, 8'd0);

        // R5: asymmetric word, longer quarters, no readout
        cur_req = "R5";
        frame(5'd8, 16'h00C5, 8'd0, 8'd2);

        // R8: readout only
        cur_req = "R8";
        frame(5'd0, 16'hFFFF, 8'd3, 8'd1);

        // R9: empty frame gives only the done pulse
        cur_req = "R9";
        frame(5'd0, 16'h0000, 8'd0, 8'd3);

        // R10: over-long command length clamps
        cur_req = "R10";
        frame(5'd20, 16'hA5C3, 8'd1, 8'd0);

        // R11: everything toggles during a running frame
        cur_req = "R11";
        @(negedge clk);
        cmd_len = 5'd3; cmd_word = 16'h0005; rd_len = 8'd1; qtr = 8'd1; rdy = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rdy = 1'b0; start = 1'b1; cmd_word = 16'h0002; cmd_len = 5'd9; rd_len = 8'd7; qtr = 8'd9;
        repeat (4) @(negedge clk);
        start = 1'b0; rdy = 1'b1;
        wait_idle();

        // R12 and R7: start held through the done cycle, back-to-back frames
        cur_req = "R12/R7";
        @(negedge clk);
        cmd_len = 5'd2; cmd_word = 16'h0002; rd_len = 8'd0; qtr = 8'd0; rdy = 1'b1; start = 1'b1;
        @(negedge clk);
        while (!m_done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        // R3: widest quarter setting, single bit
        cur_req = "R3";
        frame(5'd1, 16'h0001, 8'd0, 8'd255);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule